// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Status

This block takes a single asynchronous serial line and turns each frame into a byte. A frame is a low start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Line timing comes from an external tick that pulses `OSR` times per bit period. The receiver confirms each start bit at its midpoint and then samples every later bit at its centre.

Each finished character is written into a receive buffer register. An 8-bit status register reports the parity, framing and overrun outcome of that character. The CPU side has one read strobe, which marks the buffer as consumed. The block also raises a one-cycle completion pulse, and an error pulse in the same cycle when any error flag is set for that character.

Top module: `uart_rx_err`

## Requirements
- R1: After reset, `err_stat` is 0x00, `rx_data` is 0x00 and neither pulse is high. Bits 7..3 of `err_stat` always read 0.
- R2: A low level that returns high before the midpoint of the start bit does not start a frame and produces no completion.
- R3: Data bits are taken least significant bit first. With `char8`=1 there are 8 data bits. With `char8`=0 there are 7 data bits and `rx_data[7]` reads 0.
- R4: `par_mode` is encoded as 00 none, 01 even, 10 odd, 11 none. In the even and odd modes one parity bit follows the data, and `err_stat[2]` is set when the parity does not match. In the none modes `err_stat[2]` is 0.
- R5: `err_stat[1]` is set when the first stop bit is sampled low.
- R6: With `two_stop`=1 the second stop bit is not checked. A low second stop bit leaves `err_stat[1]` at 0, and the receiver does not hunt for a start bit during that second stop bit.
- R7: If a character completes while the previous one is still unread, `err_stat[0]` is set and the new character still replaces the buffer contents.
- R8: The overrun flag is set again for each further character until `rd_buf` is pulsed. The first character after a read has `err_stat[0]`=0.
- R9: `rx_done` is high for exactly one clock, in the cycle the buffer is loaded. `rx_err` is high in that same cycle exactly when any of the three flags is set.
- R10: All three flags are rewritten at every completion, so a clean character clears earlier errors. `rd_buf` changes neither `err_stat` nor `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Oversampling tick, OSR pulses per bit |
| par_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| two_stop | input | 1 | 1: frame carries two stop bits |
| rd_buf | input | 1 | CPU read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer register |
| err_stat | output | 8 | {5'b0, parity, framing, overrun} |
| rx_done | output | 1 | One-cycle pulse when the buffer is loaded |
| rx_err | output | 1 | One-cycle pulse when that character has an error |

## Verification
The bench builds the receiver with the default `OSR` of 16 and pulses the tick every fourth clock, so one bit lasts 64 clocks. That keeps a full frame short enough to cover every parity mode, both character lengths, both stop lengths, a rejected start glitch and a run of three unread characters within a few tens of thousands of cycles. The 16x rate also leaves eight ticks between the first low sample and the start-bit check, so a four-tick glitch falls clearly inside the rejection window.

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       os_tick,
  input  logic [1:0] par_mode,
  input  logic       char8,
  input  logic       two_stop,
  input  logic       rd_buf,
  output logic [7:0] rx_data,
  output logic [7:0] err_stat,
  output logic       rx_done,
  output logic       rx_err
);
  localparam int CW    = $clog2(2 * OSR);
  localparam int MID   = OSR / 2 - 1;
  localparam int GUARD = OSR + OSR / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_GUARD} st_t;

  st_t         st;
  logic [1:0]  sync;
  logic [CW-1:0] cnt;
  logic [2:0]  bidx;
  logic [7:0]  sh;
  logic        par_acc, full_q;
  logic        pe_q, fe_q, ov_q;

  wire rxs      = sync[1];
  wire par_on   = (par_mode == 2'b01) || (par_mode == 2'b10);
  wire last_bit = bidx == (char8 ? 3'd7 : 3'd6);
  wire at_bit   = cnt == CW'(OSR - 1);
  wire pe_n     = par_on && ((par_mode == 2'b01) ? par_acc : ~par_acc);
  wire fe_n     = ~rxs;
  wire ov_n     = full_q & ~rd_buf;

  assign err_stat = {5'b0, pe_q, fe_q, ov_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sync <= 2'b11; cnt <= '0; bidx <= '0; sh <= '0;
      par_acc <= 1'b0; full_q <= 1'b0; rx_data <= '0;
      pe_q <= 1'b0; fe_q <= 1'b0; ov_q <= 1'b0;
      rx_done <= 1'b0; rx_err <= 1'b0;
    end else begin
      sync    <= {sync[0], rx_in};
      rx_done <= 1'b0;
      rx_err  <= 1'b0;
      if (rd_buf) full_q <= 1'b0;
      if (os_tick) begin
        case (st)
          S_IDLE: if (!rxs) begin st <= S_START; cnt <= '0; end
          S_START:
            if (cnt == CW'(MID)) begin
              st <= rxs ? S_IDLE : S_DATA;
              cnt <= '0; bidx <= '0; par_acc <= 1'b0;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (at_bit) begin
              cnt <= '0;
              sh <= {rxs, sh[7:1]};
              par_acc <= par_acc ^ rxs;
              bidx <= bidx + 1'b1;
              if (last_bit) st <= par_on ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (at_bit) begin
              cnt <= '0; par_acc <= par_acc ^ rxs; st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (at_bit) begin
              cnt <= '0;
              rx_data <= char8 ? sh : {1'b0, sh[7:1]};
              pe_q <= pe_n; fe_q <= fe_n; ov_q <= ov_n;
              rx_done <= 1'b1;
              rx_err <= pe_n | fe_n | ov_n;
              full_q <= 1'b1;
              st <= two_stop ? S_GUARD : S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_GUARD:
            if (cnt == CW'(GUARD)) begin st <= S_IDLE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  assert_err_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_done);
  assert_par_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && ($past(par_mode) == 2'b00 || $past(par_mode) == 2'b11) |-> !err_stat[2]);
  assert_seven_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !$past(char8) |-> !rx_data[7]);
  assert_ovr_unread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && err_stat[0] |-> $past(full_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(err_stat) && $stable(rx_data));
endmodule

// File: tb/uart_rx_err_tb_top.sv
module uart_rx_err_tb_top;
  logic clk = 0, rst_n = 0, rx_in = 1, os_tick = 0;
  logic [1:0] par_mode = 2'b00;
  logic char8 = 1, two_stop = 0, rd_buf = 0;
  logic [7:0] rx_data, err_stat;
  logic rx_done, rx_err;

  int checks = 0, fails = 0;
  bit unread = 0, finished = 0;
  logic [7:0] exp_data = 0, exp_stat = 0;
  logic [7:0] q_data[$];
  logic q_pe[$], q_fe[$];
  string q_tag[$];
  string cur_tag = "R1";

  uart_rx_err dut_i (.clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .par_mode(par_mode), .char8(char8), .two_stop(two_stop), .rd_buf(rd_buf),
    .rx_data(rx_data), .err_stat(err_stat), .rx_done(rx_done), .rx_err(rx_err));

  always #2 clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      os_tick = (k == 3);
      k = (k + 1) % 4;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (rx_done) begin
        if (q_data.size() == 0) begin
          chk(0, "R2", "unexpected completion", 8'h1, 8'h0);
        end else begin
          exp_data = q_data.pop_front();
          exp_stat = {5'b0, q_pe.pop_front(), q_fe.pop_front(), unread};
          cur_tag = q_tag.pop_front();
          unread = 1;
          chk(rx_err == (|exp_stat), {cur_tag, " R9"}, "rx_err", {7'b0, rx_err}, {7'b0, |exp_stat});
        end
      end else begin
        chk(rx_err == 1'b0, "R9", "rx_err without done", {7'b0, rx_err}, 8'h0);
      end
      chk(err_stat == exp_stat, {cur_tag, " R10"}, "err_stat", err_stat, exp_stat);
      chk(rx_data == exp_data, {cur_tag, " R10"}, "rx_data", rx_data, exp_data);
    end
  end

  task automatic bitv(input logic v);
    rx_in = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit badpar, input bit badstop,
                      input bit bad2, input string tag);
    int nb = char8 ? 8 : 7;
    bit pon = (par_mode == 2'b01) || (par_mode == 2'b10);
    logic [7:0] dm = char8 ? d : {1'b0, d[6:0]};
    q_data.push_back(dm);
    q_pe.push_back(pon && badpar);
    q_fe.push_back(badstop);
    q_tag.push_back(tag);
    bitv(0);
    for (int i = 0; i < nb; i++) bitv(d[i]);
    if (pon) bitv(((par_mode == 2'b01) ? ^dm : ~^dm) ^ badpar);
    bitv(!badstop);
    if (two_stop) bitv(!bad2);
    bitv(1); bitv(1);
  endtask

  task automatic read_buf();
    @(negedge clk) rd_buf = 1;
    @(negedge clk) rd_buf = 0;
    unread = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(err_stat == 8'h00, "R1", "reset err_stat", err_stat, 8'h00);
    chk(rx_data == 8'h00, "R1", "reset rx_data", rx_data, 8'h00);
    chk(!rx_done && !rx_err, "R1", "reset pulses", {6'b0, rx_done, rx_err}, 8'h0);
    rst_n = 1;
    repeat (20) @(negedge clk);

    send(8'hA5, 0, 0, 0, "R3"); read_buf();
    par_mode = 2'b01;
    send(8'h3C, 0, 0, 0, "R4"); read_buf();
    send(8'h81, 1, 0, 0, "R4"); read_buf();
    par_mode = 2'b10;
    send(8'h7E, 0, 0, 0, "R10"); read_buf();
    send(8'h01, 1, 0, 0, "R4"); read_buf();
    par_mode = 2'b11;
    send(8'hC3, 1, 0, 0, "R4"); read_buf();
    par_mode = 2'b00; char8 = 0;
    send(8'hEB, 0, 0, 0, "R3"); read_buf();
    char8 = 1;
    rx_in = 0; repeat (16) @(negedge clk); rx_in = 1;
    repeat (200) @(negedge clk);
    chk(q_data.size() == 0, "R2", "glitch", 8'(q_data.size()), 8'h0);
    send(8'h12, 0, 1, 0, "R5"); read_buf();
    send(8'h5A, 0, 0, 0, "R10"); read_buf();
    two_stop = 1;
    send(8'h34, 0, 0, 1, "R6"); read_buf();
    send(8'h35, 0, 1, 0, "R6"); read_buf();
    two_stop = 0;
    send(8'h11, 0, 0, 0, "R7");
    send(8'h22, 0, 0, 0, "R7");
    send(8'h33, 0, 0, 0, "R8");
    read_buf();
    send(8'h44, 0, 0, 0, "R8"); read_buf();
    repeat (100) @(negedge clk);
    chk(q_data.size() == 0, "R9", "missing completions", 8'(q_data.size()), 8'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule